// File: doc/BRIEF.md
# Timed Multi-Cycle Interrupt Priority Arbiter

This block picks one service request out of a fixed set of sources and presents it to the CPU. Each source has a request line, an enable bit and an 8-bit priority number. A source with priority 0 never counts as a request. The search for the highest priority is a timed process called a round. Each arbitration cycle of a round settles two bits of the priority, starting at the most significant pair. Software sets how many cycles a round has (one to four) and whether each cycle takes one clock or two. A shorter round gives a faster response, but it covers a smaller priority range. Priority bits above the range that the round covers are treated as zero.

A 32-bit control word holds four things: a global interrupt enable, the read-only result of the last round, the cycle-count code and the clocks-per-cycle bit. The CPU request is raised when the global enable is set and the result is nonzero and above the CPU's current priority. When the CPU accepts a request (take strobe), the global enable is saved and cleared. The return strobe puts the saved value back. A new round starts on the clock after the previous round ends, so rounds run back to back.

Top module: `irq_prio_arbiter`

## Requirements
- R1: The control word has the global enable at bit 8, the pending priority at bits 23:16, the cycle code at bits 25:24 and the clocks-per-cycle bit at bit 26. Every other bit reads 0. Writes to the other bits and to bits 23:16 have no effect. The whole word reads 0 after reset.
- R2: The cycle code gives the number of arbitration cycles per round: 3 gives 1 cycle, 2 gives 2, 1 gives 3 and 0 gives 4. The clocks-per-cycle bit gives 1 clock per cycle when set and 2 clocks when clear. A round lasts cycles × clocks and rounds follow each other with no gap. A new setting takes effect from the next round.
- R3: The pending priority is cleared on the first clock edge of every round and loaded with the result on the last edge. When a round is longer than one clock, a nonzero result is therefore visible for exactly one clock per round.
- R4: With N cycles per round, each priority is reduced to its low 2N bits. A source is eligible when its request and its enable are both set and its reduced priority is nonzero. The result is the largest reduced priority among eligible sources, or 0 when no source is eligible.
- R5: When several eligible sources share the largest reduced priority, the lowest-numbered one wins. Its index appears on `irq_id` together with the pending priority.
- R6: `irq` is high exactly when the global enable is 1, the pending priority is nonzero and the pending priority is greater than `cpu_prio` (unsigned compare). `irq_prio` always shows the pending priority.
- R7: A take strobe saves the global enable and clears it. A return strobe restores the saved value. If take and return come in the same clock, take wins. Both strobes override a software write to bit 8 in the same clock.
- R8: Without a strobe, a software write sets the global enable to bit 8 of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NSRC | Request line per source |
| src_en | input | NSRC | Enable bit per source |
| src_prio | input | NSRC*8 | Priority of source i at bits [8i+7:8i] |
| cpu_prio | input | 8 | Current priority of the CPU |
| take | input | 1 | CPU accepts the request |
| ret | input | 1 | CPU returns from its service routine |
| csr_we | input | 1 | Control-word write strobe |
| csr_wdata | input | 32 | Control-word write data |
| csr_rdata | output | 32 | Control-word read value |
| irq | output | 1 | Request to the CPU |
| irq_prio | output | 8 | Pending priority |
| irq_id | output | $clog2(NSRC) | Index of the winning source |

## Verification
The bench sweeps all eight round settings over many request patterns. Priority values deliberately include bits above the reduced range. A design that masked the wrong bits, or started at the wrong pair, would report a wrong maximum or let a masked-out source win. Tie patterns catch a winner taken from the highest index instead of the lowest. The gap between result pulses is measured, so a design that mixed up the cycle code with the clocks-per-cycle bit would pulse at the wrong period. Take and return are checked with both saved values, together in one clock and against a software write, to catch a lost or inverted save.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W    = 8;
  localparam int NPAIR     = PRIO_W / 2;
  localparam int GIE_BIT   = 8;
  localparam int PEND_LSB  = 16;
  localparam int CODE_LSB  = 24;
  localparam int ONE_BIT   = 26;

  typedef logic [PRIO_W-1:0] prio_t;

  // index of the most significant pair a round starts with
  function automatic logic [1:0] top_pair_of(input logic [1:0] code);
    return 2'd3 - code;
  endfunction

  // keep the low 2*(top+1) bits of a priority
  function automatic prio_t range_mask(input logic [1:0] top);
    prio_t m;
    m = '0;
    for (int b = 0; b < NPAIR; b++)
      if (b <= int'(top)) m[2*b +: 2] = 2'b11;
    return m;
  endfunction

  // place a resolved pair at its position
  function automatic prio_t pair_bits(input logic [1:0] val, input logic [1:0] pair);
    return prio_t'(val) << (2 * int'(pair));
  endfunction
endpackage

// File: rtl/irq_pair_filter.sv
module irq_pair_filter
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [1:0]             pair,
  output logic [1:0]             best,
  output logic [NSRC-1:0]        keep
);
  logic [1:0] field [NSRC];

  always_comb begin
    best = 2'd0;
    for (int i = 0; i < NSRC; i++) begin
      field[i] = prio_flat[i*PRIO_W + 2*int'(pair) +: 2];
      if (cand[i] && field[i] > best) best = field[i];
    end
    for (int i = 0; i < NSRC; i++)
      keep[i] = cand[i] && (field[i] == best);
  end
endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
  parameter int NSRC = 8,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] vec,
  output logic [IDW-1:0]  idx,
  output logic            any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = NSRC - 1; i >= 0; i--)
      if (vec[i]) idx = IDW'(i);
  end
endmodule

// File: rtl/irq_round_seq.sv
module irq_round_seq
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  input  logic       one_clk,
  output logic       first,
  output logic       resolve,
  output logic       last,
  output logic [1:0] pair,
  output logic [1:0] top
);
  logic       first_q;
  logic [1:0] pair_q;
  logic [1:0] top_q;
  logic       sub_q;
  logic       one_q;
  logic       eff_one;
  logic       eff_sub;

  always_comb begin
    first   = first_q;
    eff_one = first_q ? one_clk : one_q;
    eff_sub = first_q ? 1'b0 : sub_q;
    pair    = first_q ? top_pair_of(code) : pair_q;
    top     = first_q ? top_pair_of(code) : top_q;
    resolve = eff_one | eff_sub;
    last    = resolve && (pair == 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      pair_q  <= 2'd0;
      top_q   <= 2'd0;
      sub_q   <= 1'b0;
      one_q   <= 1'b0;
    end else if (last) begin
      first_q <= 1'b1;
      sub_q   <= 1'b0;
    end else begin
      first_q <= 1'b0;
      top_q   <= top;
      one_q   <= eff_one;
      if (resolve) begin
        pair_q <= pair - 2'd1;
        sub_q  <= 1'b0;
      end else begin
        pair_q <= pair;
        sub_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_word.sv
module irq_ctrl_word
  import irq_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        take,
  input  logic        ret,
  input  prio_t       pend,
  output logic        gie,
  output logic        gie_saved,
  output logic [1:0]  code,
  output logic        one_clk,
  output logic [31:0] rdata
);
  logic       gie_q, saved_q, one_q;
  logic [1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      saved_q <= 1'b0;
      code_q  <= 2'd0;
      one_q   <= 1'b0;
    end else begin
      if (we) begin
        code_q <= wdata[CODE_LSB +: 2];
        one_q  <= wdata[ONE_BIT];
      end
      if (take) begin
        saved_q <= gie_q;
        gie_q   <= 1'b0;
      end else if (ret) begin
        gie_q   <= saved_q;
      end else if (we) begin
        gie_q   <= wdata[GIE_BIT];
      end
    end
  end

  always_comb begin
    rdata                   = '0;
    rdata[GIE_BIT]          = gie_q;
    rdata[PEND_LSB +: 8]    = pend;
    rdata[CODE_LSB +: 2]    = code_q;
    rdata[ONE_BIT]          = one_q;
    gie       = gie_q;
    gie_saved = saved_q;
    code      = code_q;
    one_clk   = one_q;
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_req,
  input  logic [NSRC-1:0]        src_en,
  input  logic [NSRC*PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]      cpu_prio,
  input  logic                   take,
  input  logic                   ret,
  input  logic                   csr_we,
  input  logic [31:0]            csr_wdata,
  output logic [31:0]            csr_rdata,
  output logic                   irq,
  output logic [PRIO_W-1:0]      irq_prio,
  output logic [IDW-1:0]         irq_id
);
  // named internal events
  logic             round_first, round_last, resolve_now;
  logic [1:0]       cur_pair, cur_top;
  logic             gie, gie_saved, one_clk;
  logic [1:0]       code;
  prio_t            mask, pend_q, acc_q, acc_base, acc_d;
  logic [NSRC-1:0]  elig, cand_q, cand_in, keep;
  logic [1:0]       best;
  logic [IDW-1:0]   win_idx, id_q;
  logic             win_any;

  irq_ctrl_word u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
    .take(take), .ret(ret), .pend(pend_q),
    .gie(gie), .gie_saved(gie_saved), .code(code), .one_clk(one_clk),
    .rdata(csr_rdata)
  );

  irq_round_seq u_seq (
    .clk(clk), .rst_n(rst_n), .code(code), .one_clk(one_clk),
    .first(round_first), .resolve(resolve_now), .last(round_last),
    .pair(cur_pair), .top(cur_top)
  );

  assign mask = range_mask(cur_top);

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = src_req[g] && src_en[g] &&
                     ((src_prio[g*PRIO_W +: PRIO_W] & mask) != '0);
  end

  assign cand_in = round_first ? elig : (cand_q & elig);

  irq_pair_filter #(.NSRC(NSRC)) u_filt (
    .cand(cand_in), .prio_flat(src_prio), .pair(cur_pair),
    .best(best), .keep(keep)
  );

  irq_first_pick #(.NSRC(NSRC)) u_pick (
    .vec(keep), .idx(win_idx), .any(win_any)
  );

  always_comb begin
    acc_base = round_first ? '0 : acc_q;
    acc_d    = resolve_now ? (acc_base | pair_bits(best, cur_pair)) : acc_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      acc_q  <= '0;
      pend_q <= '0;
      id_q   <= '0;
    end else begin
      cand_q <= resolve_now ? keep : cand_in;
      acc_q  <= acc_d;
      if (round_last) begin
        pend_q <= win_any ? acc_d : '0;
        id_q   <= win_any ? win_idx : '0;
      end else if (round_first) begin
        pend_q <= '0;
      end
    end
  end

  assign irq      = gie && (pend_q != '0) && (pend_q > cpu_prio);
  assign irq_prio = pend_q;
  assign irq_id   = id_q;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       take,
  input logic       ret,
  input logic       irq,
  input logic [7:0] irq_prio,
  input logic       gie,
  input logic       gie_saved,
  input logic       round_first,
  input logic       round_last
);
  // R3
  round_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_first && !round_last |=> irq_prio == 8'd0);
  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !round_first && !round_last |=> $stable(irq_prio));
  // R2
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_last |=> round_first);
  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie && irq_prio != 8'd0);
  // R7
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie && !irq);
  // R7
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret && !take |=> gie == $past(gie_saved));
endmodule

bind irq_prio_arbiter irq_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .ret(ret), .irq(irq),
  .irq_prio(irq_prio), .gie(gie), .gie_saved(gie_saved),
  .round_first(round_first), .round_last(round_last)
);

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic          clk = 0, rst_n = 0;
  logic [NS-1:0] src_req = '0, src_en = '0;
  logic [NS*8-1:0] src_prio = '0;
  logic [7:0]    cpu_prio = '0;
  logic          take = 0, ret = 0, csr_we = 0;
  logic [31:0]   csr_wdata = '0, csr_rdata;
  logic          irq;
  logic [7:0]    irq_prio;
  logic [1:0]    irq_id;
  int nchk = 0, nfail = 0;
  logic [31:0]   rs = 32'h1234_5678;

  irq_prio_arbiter #(.NSRC(NS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    csr_we = 1; csr_wdata = v;
    @(negedge clk);
    csr_we = 0;
  endtask

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
    return rs;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(csr_rdata == 32'h0, "R1 reset word", csr_rdata, 0);
    chk(irq == 1'b0, "R6 reset irq", irq, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reserved bits and pending field not writable
    wr(32'hFFFF_FFFF);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(csr_rdata == 32'h0700_0100, "R1 masked write", csr_rdata, 32'h0700_0100);
      @(negedge clk);
    end

    // R2 R3 R4 R5 R6 sweep over every round setting
    for (int code = 0; code < 4; code++) begin
      for (int one = 0; one < 2; one++) begin
        int ncyc, len;
        ncyc = 4 - code;
        len  = ncyc * (one ? 1 : 2);
        wr((32'(one) << 26) | (32'(code) << 24) | 32'h100);
        for (int pat = 0; pat < 24; pat++) begin
          logic [31:0] r, m;
          logic [7:0]  best, pmax, p;
          int          bid, npulse, nirq, t0, t1, idok;
          r = rnd();
          src_req  = (pat % 5 == 0) ? 4'hF : r[3:0];
          src_en   = (pat % 3 == 0) ? 4'hF : r[7:4];
          src_prio = rnd();
          if (r[8]) src_prio = {4{src_prio[7:0] ^ {6'd0, r[10:9]}}};
          if (pat == 7) src_prio = '0;
          cpu_prio = r[11] ? 8'd0 : r[23:16] & 8'h0F;
          m = (32'd1 << (2 * ncyc)) - 1;
          best = 0; bid = 0;
          for (int i = 0; i < NS; i++) begin
            p = src_prio[i*8 +: 8] & m[7:0];
            if (src_req[i] && src_en[i] && p != 0 && p > best) begin
              best = p; bid = i;
            end
          end
          repeat (20) @(negedge clk);
          npulse = 0; nirq = 0; pmax = 0; t0 = -1; t1 = -1; idok = 1;
          for (int c = 0; c < 4 * len; c++) begin
            p = csr_rdata[23:16];
            chk(p == irq_prio, "R6 irq_prio mirrors word", irq_prio, p);
            if (p != 0) begin
              npulse++;
              if (p > pmax) pmax = p;
              if (int'(irq_id) != bid) idok = 0;
              if (t0 < 0) t0 = c; else if (t1 < 0) t1 = c;
            end
            if (irq) nirq++;
            @(negedge clk);
          end
          chk(pmax == best, "R4 max reduced priority", pmax, best);
          chk(npulse == (best != 0 ? 4 : 0), "R3 one pulse per round", npulse, best != 0 ? 4 : 0);
          if (best != 0) begin
            chk(idok == 1, "R5 lowest index winner", irq_id, bid);
            chk(t1 - t0 == len, "R2 round length", t1 - t0, len);
          end
          chk(nirq == ((best != 0 && best > cpu_prio) ? 4 : 0), "R6 irq count",
              nirq, (best != 0 && best > cpu_prio) ? 4 : 0);
        end
      end
    end

    // R7 R8 strobes with a steady one-clock round
    wr(32'h0700_0100);
    src_req = 4'b0001; src_en = 4'b0001; src_prio = 32'h0000_0005; cpu_prio = 0;
    repeat (6) @(negedge clk);
    chk(irq == 1, "R8 enable by write", irq, 1);
    take = 1; @(negedge clk); take = 0;
    chk(csr_rdata[8] == 0, "R7 take clears enable", csr_rdata[8], 0);
    chk(irq == 0, "R7 no irq after take", irq, 0);
    ret = 1; @(negedge clk); ret = 0;
    chk(csr_rdata[8] == 1, "R7 return restores 1", csr_rdata[8], 1);
    chk(irq == 1, "R7 irq back after return", irq, 1);
    wr(32'h0700_0000);
    chk(csr_rdata[8] == 0, "R8 disable by write", csr_rdata[8], 0);
    chk(irq == 0, "R6 irq gated by enable", irq, 0);
    take = 1; @(negedge clk); take = 0;
    wr(32'h0700_0100);
    chk(csr_rdata[8] == 1, "R8 write inside routine", csr_rdata[8], 1);
    ret = 1; @(negedge clk); ret = 0;
    chk(csr_rdata[8] == 0, "R7 return restores 0", csr_rdata[8], 0);
    wr(32'h0700_0100);
    take = 1; ret = 1; @(negedge clk); take = 0; ret = 0;
    chk(csr_rdata[8] == 0, "R7 take wins over return", csr_rdata[8], 0);
    ret = 1; @(negedge clk); ret = 0;
    chk(csr_rdata[8] == 1, "R7 saved value after tie", csr_rdata[8], 1);
    take = 1; csr_we = 1; csr_wdata = 32'h0700_0100; @(negedge clk);
    take = 0; csr_we = 0;
    chk(csr_rdata[8] == 0, "R7 take over write", csr_rdata[8], 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule